// File: doc/BRIEF.md
# Multi-Context LUT Cluster with Per-Context Input Crossbars

This block is a cluster of four logic elements. Each element is a 4-input lookup table followed by a flip-flop. Each element has its own input crossbar, which chooses its four LUT inputs from twelve source lines. The block keeps sixteen configuration contexts. A context holds four LUT truth tables, four crossbar patterns and a feedback mask. One shared context pointer selects the active context for every element and every crossbar at once. The pointer steps through the contexts on a programmable schedule, so both the LUT functions and the wiring inside the cluster can change as often as every clock cycle. This lets one small group of elements evaluate a deep logic cone over several cycles.

The twelve source lines come from the `clusterIn` port. Any of the top four lines can be replaced, for each context, by the registered output of one element. This feedback path lets a folded computation pass partial results from one cycle and one element to the next. Configuration is written one 16-bit word at a time through an addressed port. The write port is accepted only while `rst` is high. When reset is released, the sequencer starts at context 0.

Address layout: `cfgAddr[8:5]` selects the context and `cfgAddr[4:0]` selects the word.
- Word `4*e` holds the truth table of element `e`. Bit `n` is the output for LUT input value `n`, where input 3 is the most significant bit.
- Words `4*e+1`, `4*e+2` and `4*e+3` hold crossbar bits 15:0, 31:16 and 47:32 of element `e`. Crossbar bit `12*c+s` connects source `s` to LUT input `c`.
- Word 16, bits 3:0, is the feedback mask of that context.
- Word 17 is global and ignores the context field. Bits 3:0 hold the last context index; bits 7:4 hold the dwell value.

Top module: `lcl_cluster`

## Requirements
- R1: While `rst` is high, every registered output (`clusterOut[1]`, `[3]`, `[5]`, `[7]`) is 0 after the next rising edge.
- R2: A configuration write made while `rst` is low has no effect. This applies to LUT words, crossbar words and the global word 17.
- R3: For each element `e`, `clusterOut[2e]` equals truth-table bit `{in3,in2,in1,in0}` of the active context. LUT input `c` is the source selected by the single set bit `12*c+s` of that element's crossbar.
- R4: A LUT input whose crossbar column has no bit set reads as 0.
- R5: A LUT input whose crossbar column has several bits set reads as the OR of all the selected sources.
- R6: Out of reset, `clusterOut[2e+1]` at each rising edge takes the value that `clusterOut[2e]` had just before that edge.
- R7: After reset, each context stays active for dwell+1 cycles. The contexts run in the order 0, 1, …, last, then wrap back to 0. The dwell and last values come from word 17.
- R8: The crossbar patterns and the LUT truth tables switch together to the same context, on the same clock edge.
- R9: When bit `j` of the active context's feedback mask is 1, source `8+j` is the registered output of element `j`. When the bit is 0, source `8+j` is `clusterIn[8+j]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; configuration window |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 9 | Context (8:5) and word (4:0) address |
| cfgData | input | 16 | Configuration word |
| clusterIn | input | 12 | Source lines shared by the four crossbars |
| clusterOut | output | 8 | Element e: bit 2e combinational, bit 2e+1 registered |

## Verification
The hardest case to reach from the ports is a value that travels through the feedback path while the context keeps changing. In that case the registered state of one element becomes the source of another element under a wiring that exists in only one context. To reach it, the stimulus programs a two-element counter in which one element feeds back into itself and into its neighbour. It holds the external lines that the feedback replaces at the opposite level, so a result that ignored the mask would differ. Separate runs with multi-cycle dwell and with alternating contexts that reroute the same LUT input confirm that the wiring and the truth tables switch on the same edge.

// File: rtl/lcl_pkg.sv
`timescale 1ns/1ps
package lcl_pkg;
  localparam int LE_COUNT  = 4;
  localparam int LUT_K     = 4;
  localparam int SRC_COUNT = 12;
  localparam int CTX_COUNT = 16;
  localparam int CFG_W     = 16;
  localparam int DWELL_W   = 4;

  localparam int CTX_W        = $clog2(CTX_COUNT);
  localparam int LUT_BITS     = 1 << LUT_K;
  localparam int XB_BITS      = LUT_K * SRC_COUNT;
  localparam int LE_CFG_BITS  = LUT_BITS + XB_BITS;
  localparam int WORDS_PER_LE = LE_CFG_BITS / CFG_W;
  localparam int WORD_FB      = LE_COUNT * WORDS_PER_LE;
  localparam int WORD_SEQ     = WORD_FB + 1;
  localparam int ROWS         = WORD_FB + 1;
  localparam int WORD_W       = $clog2(WORD_SEQ + 1);
  localparam int ADDR_W       = CTX_W + WORD_W;
  localparam int FB_BASE      = SRC_COUNT - LE_COUNT;
  localparam int OUT_W        = 2 * LE_COUNT;

  typedef struct packed {
    logic              cfgWr;
    logic [CTX_W-1:0]  cfgCtx;
    logic [WORD_W-1:0] cfgWord;
    logic [CFG_W-1:0]  cfgData;
    logic [CTX_W-1:0]  ctx;
    logic              run;
  } strobe_t;
endpackage

// File: rtl/lcl_xbar.sv
`timescale 1ns/1ps
module lcl_xbar
  import lcl_pkg::*;
(
  input  logic [SRC_COUNT-1:0] src,
  input  logic [XB_BITS-1:0]   cfg,
  output logic [LUT_K-1:0]     pick
);
  // one column per LUT input; zero set bits give 0, several give OR
  for (genvar c = 0; c < LUT_K; c++) begin : g_col
    assign pick[c] = |(src & cfg[c*SRC_COUNT +: SRC_COUNT]);
  end
endmodule

// File: rtl/lcl_le.sv
`timescale 1ns/1ps
module lcl_le
  import lcl_pkg::*;
(
  input  logic                clk,
  input  logic                clr,
  input  logic [LUT_BITS-1:0] truth,
  input  logic [LUT_K-1:0]    pick,
  output logic                comb,
  output logic                q
);
  assign comb = truth[pick];

  always_ff @(posedge clk) begin
    if (clr) q <= 1'b0;
    else     q <= comb;
  end
endmodule

// File: rtl/lcl_ctrl.sv
`timescale 1ns/1ps
module lcl_ctrl
  import lcl_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [CFG_W-1:0]   cfgData,
  output strobe_t            strobe,
  output logic [CTX_W-1:0]   lastCtx,
  output logic [DWELL_W-1:0] dwell
);
  localparam logic [WORD_W-1:0] FB_IDX  = WORD_W'(WORD_FB);
  localparam logic [WORD_W-1:0] SEQ_IDX = WORD_W'(WORD_SEQ);

  logic [WORD_W-1:0]  word;
  logic [CTX_W-1:0]   ctxSel;
  logic [CTX_W-1:0]   ctxQ;
  logic [DWELL_W-1:0] dwellCnt;

  assign word   = cfgAddr[WORD_W-1:0];
  assign ctxSel = cfgAddr[ADDR_W-1 -: CTX_W];

  // schedule register, writable only inside the reset window
  always_ff @(posedge clk) begin
    if (rst && cfgWe && word == SEQ_IDX) begin
      lastCtx <= cfgData[CTX_W-1:0];
      dwell   <= cfgData[CTX_W +: DWELL_W];
    end
  end

  // shared context pointer
  always_ff @(posedge clk) begin
    if (rst) begin
      ctxQ     <= '0;
      dwellCnt <= '0;
    end else if (dwellCnt == dwell) begin
      dwellCnt <= '0;
      ctxQ     <= (ctxQ == lastCtx) ? '0 : ctxQ + 1'b1;
    end else begin
      dwellCnt <= dwellCnt + 1'b1;
    end
  end

  always_comb begin
    strobe.cfgWr   = rst && cfgWe && (word <= FB_IDX);
    strobe.cfgCtx  = ctxSel;
    strobe.cfgWord = word;
    strobe.cfgData = cfgData;
    strobe.ctx     = ctxQ;
    strobe.run     = !rst;
  end
endmodule

// File: rtl/lcl_datapath.sv
`timescale 1ns/1ps
module lcl_datapath
  import lcl_pkg::*;
(
  input  logic                 clk,
  input  strobe_t              strobe,
  input  logic [SRC_COUNT-1:0] clusterIn,
  output logic [OUT_W-1:0]     clusterOut
);
  logic [CFG_W-1:0]     store [CTX_COUNT][ROWS];
  logic [LE_COUNT-1:0]  fbMask;
  logic [LE_COUNT-1:0]  combV;
  logic [LE_COUNT-1:0]  regV;
  logic [SRC_COUNT-1:0] src;
  logic                 clr;

  assign clr = !strobe.run;

  always_ff @(posedge clk) begin
    if (strobe.cfgWr) store[strobe.cfgCtx][strobe.cfgWord] <= strobe.cfgData;
  end

  assign fbMask = store[strobe.ctx][WORD_FB][LE_COUNT-1:0];

  // source lines: the top LE_COUNT may be replaced by registered feedback
  for (genvar s = 0; s < SRC_COUNT; s++) begin : g_src
    if (s >= FB_BASE) begin : g_fb
      assign src[s] = fbMask[s-FB_BASE] ? regV[s-FB_BASE] : clusterIn[s];
    end else begin : g_ext
      assign src[s] = clusterIn[s];
    end
  end

  for (genvar e = 0; e < LE_COUNT; e++) begin : g_le
    logic [LE_CFG_BITS-1:0] leCfg;
    logic [LUT_K-1:0]       pick;

    for (genvar w = 0; w < WORDS_PER_LE; w++) begin : g_word
      assign leCfg[w*CFG_W +: CFG_W] = store[strobe.ctx][e*WORDS_PER_LE + w];
    end

    lcl_xbar u_xbar (
      .src  (src),
      .cfg  (leCfg[LUT_BITS +: XB_BITS]),
      .pick (pick)
    );

    lcl_le u_le (
      .clk   (clk),
      .clr   (clr),
      .truth (leCfg[LUT_BITS-1:0]),
      .pick  (pick),
      .comb  (combV[e]),
      .q     (regV[e])
    );

    assign clusterOut[2*e]   = combV[e];
    assign clusterOut[2*e+1] = regV[e];
  end
endmodule

// File: rtl/lcl_cluster.sv
`timescale 1ns/1ps
module lcl_cluster
  import lcl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfgWe,
  input  logic [ADDR_W-1:0]    cfgAddr,
  input  logic [CFG_W-1:0]     cfgData,
  input  logic [SRC_COUNT-1:0] clusterIn,
  output logic [OUT_W-1:0]     clusterOut
);
  strobe_t            strobe;
  logic [CTX_W-1:0]   lastCtx;
  logic [DWELL_W-1:0] dwell;
  logic [CTX_W-1:0]   ctxNow;

  assign ctxNow = strobe.ctx;

  lcl_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .cfgWe   (cfgWe),
    .cfgAddr (cfgAddr),
    .cfgData (cfgData),
    .strobe  (strobe),
    .lastCtx (lastCtx),
    .dwell   (dwell)
  );

  lcl_datapath u_dp (
    .clk        (clk),
    .strobe     (strobe),
    .clusterIn  (clusterIn),
    .clusterOut (clusterOut)
  );
endmodule

// File: rtl/lcl_cluster_chk.sv
`timescale 1ns/1ps
module lcl_cluster_chk
  import lcl_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [OUT_W-1:0]   clusterOut,
  input logic [CTX_W-1:0]   ctxNow,
  input logic [CTX_W-1:0]   lastCtx,
  input logic [DWELL_W-1:0] dwell
);
  logic [LE_COUNT-1:0] regs;
  logic [LE_COUNT-1:0] combs;

  always_comb begin
    for (int e = 0; e < LE_COUNT; e++) begin
      combs[e] = clusterOut[2*e];
      regs[e]  = clusterOut[2*e+1];
    end
  end

  AST_REG_CLEAR: assert property (@(posedge clk) disable iff (!rst)
    rst |=> (regs == '0)); // R1

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(lastCtx) && $stable(dwell))); // R2

  AST_REG_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (regs == $past(combs))); // R6

  AST_CTX_BOUND: assert property (@(posedge clk) disable iff (rst)
    ctxNow <= lastCtx); // R7

  AST_CTX_STEP: assert property (@(posedge clk) disable iff (rst)
    (ctxNow != $past(ctxNow)) |->
      ((ctxNow == CTX_W'($past(ctxNow) + 1'b1)) ||
       (ctxNow == '0 && $past(ctxNow) == lastCtx))); // R7
endmodule

bind lcl_cluster lcl_cluster_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .clusterOut (clusterOut),
  .ctxNow     (ctxNow),
  .lastCtx    (lastCtx),
  .dwell      (dwell)
);

// File: tb/sim_lcl_cluster.sv
`timescale 1ns/1ps
module sim_lcl_cluster;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfgWe = 1'b0;
  logic [8:0]  cfgAddr = '0;
  logic [15:0] cfgData = '0;
  logic [11:0] clusterIn = '0;
  logic [7:0]  clusterOut;

  always #2.5 clk = ~clk;

  lcl_cluster u0 (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .clusterIn(clusterIn), .clusterOut(clusterOut)
  );

  int nChecks = 0;
  int nFails  = 0;

  // shadow of the programmed configuration and a cycle model
  logic [15:0] mLut [16][4];
  logic [47:0] mXb  [16][4];
  logic [3:0]  mFb  [16];
  int          mLast, mDwell, mCtx, mCnt;
  logic [3:0]  mReg;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
  endtask

  task automatic wr(input int ctx, input int word, input logic [15:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = {4'(ctx), 5'(word)}; cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic progLe(input int ctx, input int le, input logic [15:0] lut, input logic [47:0] xb);
    wr(ctx, le*4,   lut);
    wr(ctx, le*4+1, xb[15:0]);
    wr(ctx, le*4+2, xb[31:16]);
    wr(ctx, le*4+3, xb[47:32]);
    mLut[ctx][le] = lut;
    mXb[ctx][le]  = xb;
  endtask

  task automatic progFb(input int ctx, input logic [3:0] mask);
    wr(ctx, 16, {12'h000, mask});
    mFb[ctx] = mask;
  endtask

  task automatic progSeq(input int last, input int dw);
    wr(0, 17, {8'h00, 4'(dw), 4'(last)});
    mLast = last; mDwell = dw;
  endtask

  task automatic holdReset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
  endtask

  task automatic clearAll();
    for (int c = 0; c < 16; c++) begin
      for (int w = 0; w < 17; w++) wr(c, w, 16'h0000);
      for (int e = 0; e < 4; e++) begin mLut[c][e] = '0; mXb[c][e] = '0; end
      mFb[c] = '0;
    end
  endtask

  task automatic startRun();
    rst = 1'b0; mCtx = 0; mCnt = 0; mReg = '0;
  endtask

  function automatic logic [47:0] xbPick(input int s0, input int s1, input int s2, input int s3);
    logic [47:0] r = '0;
    if (s0 >= 0) r[0*12+s0] = 1'b1;
    if (s1 >= 0) r[1*12+s1] = 1'b1;
    if (s2 >= 0) r[2*12+s2] = 1'b1;
    if (s3 >= 0) r[3*12+s3] = 1'b1;
    return r;
  endfunction

  function automatic logic [3:0] expComb(input logic [11:0] ins);
    logic [3:0]  r;
    logic [11:0] src;
    logic [3:0]  b;
    src = ins;
    for (int j = 0; j < 4; j++) if (mFb[mCtx][j]) src[8+j] = mReg[j];
    for (int e = 0; e < 4; e++) begin
      for (int c = 0; c < 4; c++) b[c] = |(src & mXb[mCtx][e][c*12 +: 12]);
      r[e] = mLut[mCtx][e][b];
    end
    return r;
  endfunction

  // one cycle: drive, check combinational and registered outputs, advance model
  task automatic step(input logic [11:0] ins, input string tag);
    logic [3:0] e, evens, odds;
    clusterIn = ins;
    #1;
    e     = expComb(ins);
    evens = {clusterOut[6], clusterOut[4], clusterOut[2], clusterOut[0]};
    odds  = {clusterOut[7], clusterOut[5], clusterOut[3], clusterOut[1]};
    check(evens == e, tag, evens, e);
    check(odds == mReg, "R6 registered output", odds, mReg);
    @(posedge clk);
    mReg = e;
    if (mCnt == mDwell) begin
      mCnt = 0;
      mCtx = (mCtx == mLast) ? 0 : mCtx + 1;
    end else mCnt++;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [3:0] odds;
    holdReset();
    clearAll();
    progSeq(0, 0);
    for (int e = 0; e < 4; e++) progLe(0, e, 16'hFFFF, '0);
    odds = {clusterOut[7], clusterOut[5], clusterOut[3], clusterOut[1]};
    check(odds == 4'h0, "R1 registered outputs in reset", odds, 0);
    startRun();
    step(12'h000, "R3 constant one");
    step(12'hFFF, "R3 constant one");
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      clusterIn = 12'(i * 12'h5A3);
      @(negedge clk);
      odds = {clusterOut[7], clusterOut[5], clusterOut[3], clusterOut[1]};
      check(odds == 4'h0, "R1 registered cleared under reset", odds, 0);
    end
  endtask

  task automatic t_route();
    logic [11:0] pats [8] = '{12'h000, 12'hFFF, 12'h00F, 12'hA5A, 12'h5A5, 12'h3C0, 12'h0F1, 12'h888};
    holdReset();
    clearAll();
    progSeq(0, 0);
    progLe(0, 0, 16'h8000, xbPick(0, 1, 2, 3));
    progLe(0, 1, 16'hAAAA, xbPick(7, -1, -1, -1));
    progLe(0, 2, 16'h6996, xbPick(11, 4, 9, 5));
    progLe(0, 3, 16'h1234, xbPick(10, 8, 6, 0));
    startRun();
    foreach (pats[i]) step(pats[i], "R3 single crosspoint routing");
  endtask

  task automatic t_empty();
    holdReset();
    clearAll();
    progSeq(0, 0);
    progLe(0, 0, 16'hAAAA, xbPick(-1, -1, -1, -1));
    progLe(0, 1, 16'h0001, xbPick(-1, -1, -1, -1));
    progLe(0, 2, 16'hAAAA, xbPick(-1, 3, -1, -1));
    progLe(0, 3, 16'h00FF, xbPick(-1, -1, -1, 2));
    startRun();
    step(12'hFFF, "R4 empty column reads zero");
    step(12'h004, "R4 empty column reads zero");
    step(12'h000, "R4 empty column reads zero");
    step(12'hABC, "R4 empty column reads zero");
  endtask

  task automatic t_or();
    logic [47:0] x0, x1;
    holdReset();
    clearAll();
    progSeq(0, 0);
    x0 = xbPick(2, -1, -1, -1); x0[5] = 1'b1;
    x1 = xbPick(0, 3, 6, 9);    x1[1] = 1'b1; x1[12+4] = 1'b1;
    progLe(0, 0, 16'hAAAA, x0);
    progLe(0, 1, 16'h8000, x1);
    startRun();
    step(12'h000, "R5 multiple crosspoints OR");
    step(12'h004, "R5 multiple crosspoints OR");
    step(12'h020, "R5 multiple crosspoints OR");
    step(12'h24A, "R5 multiple crosspoints OR");
    step(12'h259, "R5 multiple crosspoints OR");
    step(12'h251, "R5 multiple crosspoints OR");
  endtask

  task automatic t_seq();
    holdReset();
    clearAll();
    progSeq(2, 1);
    progLe(1, 0, 16'hFFFF, '0);
    progLe(2, 1, 16'hFFFF, '0);
    progLe(0, 2, 16'hAAAA, xbPick(0, -1, -1, -1));
    startRun();
    for (int i = 0; i < 14; i++) step(12'(i), "R7 context schedule dwell 1 last 2");
    holdReset();
    progSeq(3, 0);
    progLe(3, 3, 16'hFFFF, '0);
    startRun();
    for (int i = 0; i < 10; i++) step(12'(i * 3), "R7 context schedule dwell 0 last 3");
  endtask

  task automatic t_lockstep();
    logic [11:0] pats [6] = '{12'h008, 12'h040, 12'h048, 12'h000, 12'h00F, 12'h040};
    holdReset();
    clearAll();
    progSeq(1, 0);
    progLe(0, 0, 16'hAAAA, xbPick(3, -1, -1, -1));
    progLe(1, 0, 16'hAAAA, xbPick(6, -1, -1, -1));
    progLe(0, 1, 16'h8000, xbPick(0, 1, 2, 3));
    progLe(1, 1, 16'h5555, xbPick(3, -1, -1, -1));
    startRun();
    foreach (pats[i]) step(pats[i], "R8 wiring and truth table switch together");
  endtask

  task automatic t_feedback();
    holdReset();
    clearAll();
    progSeq(0, 0);
    progFb(0, 4'b0011);
    progLe(0, 0, 16'h5555, xbPick(8, -1, -1, -1));
    progLe(0, 1, 16'h6666, xbPick(8, 9, -1, -1));
    progLe(0, 2, 16'hAAAA, xbPick(9, -1, -1, -1));
    progLe(0, 3, 16'hAAAA, xbPick(10, -1, -1, -1));
    startRun();
    for (int i = 0; i < 10; i++)
      step({1'b0, 1'(i), 2'b11, 8'h00}, "R9 feedback replaces masked sources");
  endtask

  task automatic t_noWrite();
    holdReset();
    clearAll();
    progSeq(1, 0);
    progLe(0, 0, 16'hAAAA, xbPick(0, -1, -1, -1));
    progLe(1, 0, 16'h5555, xbPick(1, -1, -1, -1));
    progLe(0, 1, 16'h8000, xbPick(0, 1, 2, 3));
    startRun();
    step(12'h001, "R3 before run-time write");
    cfgWe = 1'b1; cfgAddr = {4'd0, 5'd0}; cfgData = 16'h5555;
    step(12'h001, "R2 LUT write during run ignored");
    step(12'h002, "R2 LUT write during run ignored");
    step(12'h00F, "R2 LUT write during run ignored");
    cfgAddr = {4'd0, 5'd1}; cfgData = 16'hFFFF;
    step(12'h000, "R2 crossbar write during run ignored");
    step(12'h003, "R2 crossbar write during run ignored");
    cfgAddr = {4'd0, 5'd17}; cfgData = 16'h0030;
    step(12'h000, "R2 schedule write during run ignored");
    step(12'h001, "R2 schedule write during run ignored");
    cfgWe = 1'b0;
    for (int i = 0; i < 4; i++) step(12'(i), "R2 configuration unchanged after run-time writes");
  endtask

  initial begin
    #500000;
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_route();
    t_empty();
    t_or();
    t_seq();
    t_lockstep();
    t_feedback();
    t_noWrite();
    summary();
    $finish;
  end
endmodule